// File: doc/BRIEF.md
# Variable-length instruction decoder

This block splits one instruction out of a ten-byte fetch window that begins at the current program counter. It reads the opcode and function nibbles from the first byte and derives from the opcode alone how many bytes the instruction occupies. It then extracts the register specifier byte and the 64-bit constant where they are present, adds the length to the program counter to give the sequential successor address, and classifies the result with a status code. Execution, memory access and pipeline control belong to other blocks.

All decoded values are computed in one combinational process and captured in a single register stage, so each output reflects the inputs presented on the previous rising clock edge. A fetch-fault input from instruction memory turns the status into a bad-address indication regardless of what the bytes contain.

Top module: `insn_decoder`

## Requirements
- R1: One cycle after the inputs are sampled, `icode_o` equals bits 7:4 of window byte 0 and `ifun_o` equals bits 3:0 of byte 0 (byte k of the window sits at bits 8k+7:8k of `fetch_i`).
- R2: For opcodes 2, 3, 4, 5, 6, 0xA and 0xB, `ra_o` is bits 7:4 and `rb_o` is bits 3:0 of byte 1; for every other opcode both read 0xF, the code for no register.
- R3: For opcodes 3, 4 and 5, `valc_o` is bytes 2 to 9 taken little-endian (byte 2 least significant); for opcodes 7 and 8 it is bytes 1 to 8 taken the same way; for all other opcodes it is zero.
- R4: `len_o` is 1 for opcodes 0, 1 and 9, 2 for opcodes 2, 6, 0xA and 0xB, 9 for opcodes 7 and 8, 10 for opcodes 3, 4 and 5, and 1 for opcodes 0xC to 0xF; `valp_o` equals the sampled PC plus `len_o`, modulo 2^64.
- R5: Status encodings are OK=1, halted=2, bad address=3, invalid instruction=4; a valid instruction with opcode 0 gives 2 (so an all-zero byte halts) and any other valid instruction gives 1.
- R6: Status 4 results from an opcode above 0xB, from a nonzero function code on opcodes 0, 1, 3, 4, 5, 8, 9, 0xA or 0xB, from a function code above 3 on opcode 6, or from a function code above 6 on opcodes 2 and 7.
- R7: When `imem_err_i` is high the status is 3, taking priority over both invalid-instruction and halted.
- R8: While `rst_n` is low the outputs read opcode 1, function 0, both registers 0xF, constant 0, length 1, successor address 0 and status 1.

Top module port order follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 64 | Address of window byte 0 |
| fetch_i | input | 80 | Fetch window, byte 0 in the low bits |
| imem_err_i | input | 1 | Instruction fetch fault |
| icode_o | output | 4 | Opcode nibble |
| ifun_o | output | 4 | Function nibble |
| ra_o | output | 4 | First register specifier |
| rb_o | output | 4 | Second register specifier |
| valc_o | output | 64 | Constant or destination address |
| len_o | output | 4 | Instruction length in bytes |
| valp_o | output | 64 | Sequential successor address |
| stat_o | output | 3 | Status code |

## Verification
Directed windows cover every opcode once with a legal function code, which separates the four length classes and shows whether the constant is pulled from byte 1 or byte 2 onward; the little-endian worked example with constant 0xabcd distinguishes byte order. Illegal function codes sit just above each opcode's limit and legal ones just at it, telling an off-by-one limit apart from a correct one, and the fault input is raised together with halt and invalid bytes to expose the priority order. Random windows with PCs near the top of the address space then exercise the carry and wrap of the successor address against a behavioural model every cycle.

// File: rtl/insn_decoder_pkg.sv
package insn_decoder_pkg;

    parameter int ADDR_W      = 64;
    parameter int CONST_BYTES = 8;
    parameter int WIN_BYTES   = CONST_BYTES + 2;
    parameter int NIB_W       = 4;
    parameter int CONST_W     = 8 * CONST_BYTES;
    parameter int LEN_W       = $clog2(WIN_BYTES + 1);

    parameter logic [NIB_W-1:0] REG_NONE = 4'hF;

    typedef enum logic [3:0] {
        OP_HALT  = 4'h0,
        OP_NOP   = 4'h1,
        OP_CMOV  = 4'h2,
        OP_IRMOV = 4'h3,
        OP_RMMOV = 4'h4,
        OP_MRMOV = 4'h5,
        OP_ALU   = 4'h6,
        OP_JUMP  = 4'h7,
        OP_CALL  = 4'h8,
        OP_RET   = 4'h9,
        OP_PUSH  = 4'hA,
        OP_POP   = 4'hB
    } opcode_e;

    typedef enum logic [2:0] {
        ST_AOK = 3'd1,
        ST_HLT = 3'd2,
        ST_ADR = 3'd3,
        ST_INS = 3'd4
    } status_e;

    typedef struct packed {
        logic [NIB_W-1:0]   icode;
        logic [NIB_W-1:0]   ifun;
        logic [NIB_W-1:0]   ra;
        logic [NIB_W-1:0]   rb;
        logic [CONST_W-1:0] valc;
        logic [LEN_W-1:0]   len;
        logic [ADDR_W-1:0]  valp;
        status_e            stat;
    } decode_t;

endpackage

// File: rtl/ivd_length.sv
module ivd_length
    import insn_decoder_pkg::*;
#(
    parameter int CB = CONST_BYTES,
    parameter int LW = LEN_W
) (
    input  logic [NIB_W-1:0] icode,
    output logic             has_reg,
    output logic             has_val,
    output logic             dest_form,
    output logic [LW-1:0]    len
);

    localparam int LEN_ONE  = 1;
    localparam int LEN_REG  = 2;
    localparam int LEN_DEST = CB + 1;
    localparam int LEN_FULL = CB + 2;

    always_comb begin
        has_reg   = 1'b0;
        has_val   = 1'b0;
        dest_form = 1'b0;
        len       = LW'(LEN_ONE);
        case (icode)
            OP_CMOV, OP_ALU, OP_PUSH, OP_POP: begin
                has_reg = 1'b1;
                len     = LW'(LEN_REG);
            end
            OP_IRMOV, OP_RMMOV, OP_MRMOV: begin
                has_reg = 1'b1;
                has_val = 1'b1;
                len     = LW'(LEN_FULL);
            end
            OP_JUMP, OP_CALL: begin
                has_val   = 1'b1;
                dest_form = 1'b1;
                len       = LW'(LEN_DEST);
            end
            default: len = LW'(LEN_ONE);
        endcase
    end

endmodule

// File: rtl/ivd_fields.sv
module ivd_fields
    import insn_decoder_pkg::*;
#(
    parameter int WB = WIN_BYTES,
    parameter int CB = CONST_BYTES
) (
    input  logic [8*(WB-1)-1:0] tail,
    input  logic                has_reg,
    input  logic                has_val,
    input  logic                dest_form,
    output logic [NIB_W-1:0]    ra,
    output logic [NIB_W-1:0]    rb,
    output logic [8*CB-1:0]     valc
);

    always_comb begin
        if (has_reg) begin
            ra = tail[7:4];
            rb = tail[3:0];
        end else begin
            ra = REG_NONE;
            rb = REG_NONE;
        end
    end

    for (genvar k = 0; k < CB; k++) begin : g_const_byte
        logic [7:0] pick;
        always_comb begin
            pick = dest_form ? tail[8*k +: 8] : tail[8*(k+1) +: 8];
            valc[8*k +: 8] = has_val ? pick : 8'h00;
        end
    end

endmodule

// File: rtl/ivd_check.sv
module ivd_check
    import insn_decoder_pkg::*;
(
    input  logic [NIB_W-1:0] icode,
    input  logic [NIB_W-1:0] ifun,
    input  logic             fetch_fault,
    output status_e          stat
);

    logic             known;
    logic [NIB_W-1:0] fn_max;

    always_comb begin
        known  = 1'b1;
        fn_max = '0;
        case (icode)
            OP_CMOV, OP_JUMP: fn_max = 4'd6;
            OP_ALU:           fn_max = 4'd3;
            OP_HALT, OP_NOP, OP_IRMOV, OP_RMMOV, OP_MRMOV,
            OP_CALL, OP_RET, OP_PUSH, OP_POP: fn_max = 4'd0;
            default:          known  = 1'b0;
        endcase
    end

    always_comb begin
        if (fetch_fault)
            stat = ST_ADR;
        else if (!known || ifun > fn_max)
            stat = ST_INS;
        else if (icode == OP_HALT)
            stat = ST_HLT;
        else
            stat = ST_AOK;
    end

endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
    import insn_decoder_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CB = CONST_BYTES,
    parameter int WB = WIN_BYTES,
    parameter int LW = LEN_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   pc_i,
    input  logic [8*WB-1:0] fetch_i,
    input  logic            imem_err_i,
    output logic [3:0]      icode_o,
    output logic [3:0]      ifun_o,
    output logic [3:0]      ra_o,
    output logic [3:0]      rb_o,
    output logic [8*CB-1:0] valc_o,
    output logic [LW-1:0]   len_o,
    output logic [AW-1:0]   valp_o,
    output logic [2:0]      stat_o
);

    localparam decode_t RESET_VAL = '{
        icode: OP_NOP,
        ifun:  '0,
        ra:    REG_NONE,
        rb:    REG_NONE,
        valc:  '0,
        len:   LW'(1),
        valp:  '0,
        stat:  ST_AOK
    };

    logic [NIB_W-1:0] op_nib;
    logic [NIB_W-1:0] fn_nib;
    logic             has_reg;
    logic             has_val;
    logic             dest_form;
    logic [LW-1:0]    len_w;
    logic [NIB_W-1:0] ra_w;
    logic [NIB_W-1:0] rb_w;
    logic [8*CB-1:0]  valc_w;
    status_e          stat_w;

    decode_t dec_d;
    decode_t dec_q;

    assign op_nib = fetch_i[7:4];
    assign fn_nib = fetch_i[3:0];

    ivd_length #(.CB(CB), .LW(LW)) u_length (
        .icode     (op_nib),
        .has_reg   (has_reg),
        .has_val   (has_val),
        .dest_form (dest_form),
        .len       (len_w)
    );

    ivd_fields #(.WB(WB), .CB(CB)) u_fields (
        .tail      (fetch_i[8*WB-1:8]),
        .has_reg   (has_reg),
        .has_val   (has_val),
        .dest_form (dest_form),
        .ra        (ra_w),
        .rb        (rb_w),
        .valc      (valc_w)
    );

    ivd_check u_check (
        .icode       (op_nib),
        .ifun        (fn_nib),
        .fetch_fault (imem_err_i),
        .stat        (stat_w)
    );

    always_comb begin
        dec_d       = RESET_VAL;
        dec_d.icode = op_nib;
        dec_d.ifun  = fn_nib;
        dec_d.ra    = ra_w;
        dec_d.rb    = rb_w;
        dec_d.valc  = valc_w;
        dec_d.len   = len_w;
        dec_d.valp  = pc_i + {{(AW-LW){1'b0}}, len_w};
        dec_d.stat  = stat_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            dec_q <= RESET_VAL;
        else
            dec_q <= dec_d;
    end

    assign icode_o = dec_q.icode;
    assign ifun_o  = dec_q.ifun;
    assign ra_o    = dec_q.ra;
    assign rb_o    = dec_q.rb;
    assign valc_o  = dec_q.valc;
    assign len_o   = dec_q.len;
    assign valp_o  = dec_q.valp;
    assign stat_o  = dec_q.stat;

endmodule

// File: rtl/insn_decoder_checker.sv
module insn_decoder_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] pc_i,
    input logic [7:0]  byte0,
    input logic        imem_err_i,
    input logic [3:0]  icode_o,
    input logic [3:0]  ra_o,
    input logic [3:0]  rb_o,
    input logic [3:0]  len_o,
    input logic [63:0] valp_o,
    input logic [2:0]  stat_o
);

    assert_successor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (valp_o == $past(pc_i) + {60'd0, len_o}));

    assert_len_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (len_o == 4'd1 || len_o == 4'd2 || len_o == 4'd9 || len_o == 4'd10));

    assert_status_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o >= 3'd1 && stat_o <= 3'd4));

    assert_zero_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte0 == 8'h00 && !imem_err_i) |=> (stat_o == 3'd2 && len_o == 4'd1));

    assert_fault_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        imem_err_i |=> (stat_o == 3'd3));

    assert_high_opcode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte0[7:4] > 4'hB && !imem_err_i) |=> (stat_o == 3'd4));

    assert_no_reg_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (icode_o == 4'h0 || icode_o == 4'h1 || icode_o == 4'h7 ||
         icode_o == 4'h8 || icode_o == 4'h9) |-> (ra_o == 4'hF && rb_o == 4'hF));

endmodule

bind insn_decoder insn_decoder_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_i       (pc_i),
    .byte0      (fetch_i[7:0]),
    .imem_err_i (imem_err_i),
    .icode_o    (icode_o),
    .ra_o       (ra_o),
    .rb_o       (rb_o),
    .len_o      (len_o),
    .valp_o     (valp_o),
    .stat_o     (stat_o)
);

// File: tb/insn_decoder_test.sv
module insn_decoder_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] pc_i = '0;
    logic [79:0] fetch_i = '0;
    logic        imem_err_i = 1'b0;
    logic [3:0]  icode_o, ifun_o, ra_o, rb_o, len_o;
    logic [63:0] valc_o, valp_o;
    logic [2:0]  stat_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    insn_decoder uut (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .fetch_i(fetch_i),
        .imem_err_i(imem_err_i), .icode_o(icode_o), .ifun_o(ifun_o),
        .ra_o(ra_o), .rb_o(rb_o), .valc_o(valc_o), .len_o(len_o),
        .valp_o(valp_o), .stat_o(stat_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] bytek(input logic [79:0] w, input int k);
        return w[8*k +: 8];
    endfunction

    // Behavioural model: apply vector, wait one cycle, compare.
    task automatic apply(input logic [63:0] pc, input logic [79:0] w, input bit err);
        int op, fn, n, limit, constat;
        logic [63:0] ev;
        logic [3:0] era, erb;
        int st;
        bit legal;
        string stag;
        pc_i = pc; fetch_i = w; imem_err_i = err;
        op = int'(w[7:4]); fn = int'(w[3:0]);
        n = 1; era = 4'hF; erb = 4'hF; ev = 64'd0; constat = -1;
        if (op == 2 || op == 6 || op == 10 || op == 11) n = 2;
        if (op >= 3 && op <= 5) begin n = 10; constat = 2; end
        if (op == 7 || op == 8) begin n = 9; constat = 1; end
        if (n >= 2 && constat != 1) begin era = w[15:12]; erb = w[11:8]; end
        if (constat >= 0)
            for (int i = 7; i >= 0; i--) ev = (ev << 8) | 64'(bytek(w, constat + i));
        limit = -1;
        if (op == 2 || op == 7) limit = 6;
        else if (op == 6) limit = 3;
        else if (op <= 11) limit = 0;
        legal = (limit >= 0) && (fn <= limit);
        if (err) begin st = 3; stag = "R7"; end
        else if (!legal) begin st = 4; stag = "R6"; end
        else begin st = (op == 0) ? 2 : 1; stag = "R5"; end
        @(negedge clk);
        check("R1", "icode", 64'(icode_o), 64'(op));
        check("R1", "ifun", 64'(ifun_o), 64'(fn));
        check("R2", "ra", 64'(ra_o), 64'(era));
        check("R2", "rb", 64'(rb_o), 64'(erb));
        check("R3", "valc", valc_o, ev);
        check("R4", "len", 64'(len_o), 64'(n));
        check("R4", "valp", valp_o, pc + 64'(n));
        check(stag, "stat", 64'(stat_o), 64'(st));
    endtask

    function automatic logic [79:0] win(input logic [7:0] b0, input logic [7:0] b1,
                                        input logic [63:0] rest);
        return {rest, b1, b0};
    endfunction

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        logic [79:0] w;
        logic [63:0] pc;
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8", "icode", 64'(icode_o), 64'd1);
        check("R8", "ifun", 64'(ifun_o), 64'd0);
        check("R8", "ra", 64'(ra_o), 64'hF);
        check("R8", "rb", 64'(rb_o), 64'hF);
        check("R8", "valc", valc_o, 64'd0);
        check("R8", "len", 64'(len_o), 64'd1);
        check("R8", "valp", valp_o, 64'd0);
        check("R8", "stat", 64'(stat_o), 64'd1);
        rst_n = 1'b1;

        // worked little-endian example: 30 82 cd ab 00 ...
        apply(64'h100, win(8'h30, 8'h82, 64'h0000_0000_0000_abcd), 0);
        check("R3", "example valc", valc_o, 64'h abcd);
        // each opcode with legal function
        for (int op = 0; op < 16; op++)
            apply(64'h1000 + 64'(op), win({4'(op), 4'h0}, 8'h5A, 64'h8877_6655_4433_2211), 0);
        // destination form takes bytes 1..8
        apply(64'h40, win(8'h70, 8'h11, 64'h0088_7766_5544_3322), 0);
        apply(64'h40, win(8'h80, 8'hEF, 64'hFF01_2345_6789_ABCD), 0);
        // function limits: at and just above
        apply(64'h0, win(8'h63, 8'h12, 64'h0), 0);
        apply(64'h0, win(8'h64, 8'h12, 64'h0), 0);
        apply(64'h0, win(8'h26, 8'h34, 64'h0), 0);
        apply(64'h0, win(8'h27, 8'h34, 64'h0), 0);
        apply(64'h0, win(8'h76, 8'h00, 64'h0), 0);
        apply(64'h0, win(8'h77, 8'h00, 64'h0), 0);
        apply(64'h0, win(8'h31, 8'hF2, 64'h0), 0);
        apply(64'h0, win(8'h01, 8'h00, 64'h0), 0);
        apply(64'h0, win(8'hB1, 8'h3F, 64'h0), 0);
        // all zero halts; fault priority over halt and invalid
        apply(64'h200, 80'd0, 0);
        apply(64'h200, 80'd0, 1);
        apply(64'h200, win(8'hF0, 8'h00, 64'h0), 1);
        apply(64'h200, win(8'h65, 8'h00, 64'h0), 1);
        // successor wrap at top of address space
        apply(64'hFFFF_FFFF_FFFF_FFFA, win(8'h30, 8'hF1, 64'h1), 0);
        apply(64'hFFFF_FFFF_FFFF_FFFF, win(8'h10, 8'h00, 64'h0), 0);
        // random windows
        for (int i = 0; i < 400; i++) begin
            w = {$urandom, $urandom, $urandom};
            if (($urandom % 2) == 0) w[3:0] = 4'($urandom % 4);
            pc = {$urandom, $urandom};
            if ((i % 5) == 0) pc = 64'hFFFF_FFFF_FFFF_FFF0 | 64'($urandom % 16);
            apply(pc, w, ($urandom % 8) == 0);
        end
        // reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R8", "stat after reset", 64'(stat_o), 64'd1);
        check("R8", "ra after reset", 64'(ra_o), 64'hF);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule